// File: doc/BRIEF.md
# Programmable sum-of-products plane

This block is the logic core of a small programmable logic device: a wide AND plane whose connections come from stored configuration words, feeding a fixed OR plane. Twelve dedicated inputs and ten feedback signals from the output cells are each offered in true and inverted form. Each of 132 product-term rows forms the AND of the columns it keeps connected. The rows are split into one global asynchronous-reset term, one global synchronous-preset term, and ten output groups. Each group holds one output-enable term and a run of OR terms, and the run lengths differ from group to group.

Configuration is written one row at a time through a parallel port while the program-enable input is high. During that time every array result is forced low. A readback port returns any stored row. Once the lock bit is set, readback reports every bit as blown (all ones) until reset. The plane holds no state beyond its configuration and lock bit, and the results are purely combinational in the inputs and feedbacks.

Top module: `sop_plane`

## Requirements
- R1: Signal s is `din[s]` for s < 12 and `fb[s-12]` otherwise. Column 2s carries s true and column 2s+1 carries s inverted. In a row word, bit c = 1 removes column c from that term and bit c = 0 keeps it.
- R2: A row whose word is all ones evaluates HIGH whatever the inputs are.
- R3: A row that keeps both the true and the inverted column of the same signal evaluates LOW.
- R4: Reset clears every row word to zero, so every term is connected to everything and is LOW. Reset also clears the lock bit. After reset, `sop`, `oe`, `ar` and `sp` are all 0 and readback returns 0.
- R5: Row 0 drives `ar` and row 131 drives `sp`. The output groups run from output 9 down to output 0, starting at row 1. A group is one enable row followed by its OR rows. The counts of OR rows for outputs 9 down to 0 are 8, 10, 12, 14, 16, 16, 14, 12, 10, 8, so output 4 uses rows 66 (enable) and 67..82, and output 0 uses rows 122 (enable) and 123..130.
- R6: `sop[k]` is the OR of output k's OR rows, and `oe[k]` is the value of its enable row.
- R7: A row write with `cfg_we` takes effect on the rising clock edge only when `prog_en` is high and `cfg_row` is below 132. Any other write changes no stored row.
- R8: While `prog_en` is high, `sop`, `oe`, `ar` and `sp` are all 0.
- R9: While unlocked, `rd_data` shows the stored word of row `rd_row`. It shows 0 when `rd_row` is 132 or above. A written word can be read back from the cycle after the edge that stores it.
- R10: `cfg_lock` high together with `prog_en` at a rising edge sets the lock. From then until reset, `rd_data` is all ones for every row, and the array keeps evaluating the stored words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | Programming mode; gates writes and forces results low |
| cfg_we | input | 1 | Row write strobe |
| cfg_row | input | 8 | Row written |
| cfg_data | input | 44 | Row word, one bit per column (1 = removed) |
| cfg_lock | input | 1 | Sets the readback lock |
| rd_row | input | 8 | Row read back |
| rd_data | output | 44 | Read-back word |
| din | input | 12 | Dedicated inputs |
| fb | input | 10 | Feedback from the output cells |
| sop | output | 10 | Sum-of-products result per output |
| oe | output | 10 | Enable term per output |
| ar | output | 1 | Global asynchronous-reset term |
| sp | output | 1 | Global synchronous-preset term |

## Verification
A row write and the lock request can land on the same clock edge. The bench provokes this by replacing the second OR row of output 9 in the same cycle that it raises `cfg_lock`. It then judges both halves of that edge. Readback of the rewritten row and of row 0 must return all ones. After programming ends, `sop[9]` must follow the new word and no longer the old feedback term.

// File: rtl/sop_plane.sv
module sop_plane #(
  parameter int NUM_IN    = 12,
  parameter int NUM_OUT   = 10,
  parameter int MIN_TERMS = 8,
  parameter int TERM_STEP = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           prog_en,
  input  logic                           cfg_we,
  input  logic [7:0]                     cfg_row,
  input  logic [2*(NUM_IN+NUM_OUT)-1:0]  cfg_data,
  input  logic                           cfg_lock,
  input  logic [7:0]                     rd_row,
  output logic [2*(NUM_IN+NUM_OUT)-1:0]  rd_data,
  input  logic [NUM_IN-1:0]              din,
  input  logic [NUM_OUT-1:0]             fb,
  output logic [NUM_OUT-1:0]             sop,
  output logic [NUM_OUT-1:0]             oe,
  output logic                           ar,
  output logic                           sp
);

  function automatic int term_cnt(input int k);
    int j, h;
    j = NUM_OUT - 1 - k;
    h = (j < NUM_OUT - 1 - j) ? j : NUM_OUT - 1 - j;
    return MIN_TERMS + TERM_STEP * h;
  endfunction

  function automatic int grp_start(input int k);
    int s;
    s = 1;
    for (int m = NUM_OUT - 1; m > k; m--) s += 1 + term_cnt(m);
    return s;
  endfunction

  localparam int NUM_SIG  = NUM_IN + NUM_OUT;
  localparam int NUM_COL  = 2 * NUM_SIG;
  localparam int NUM_ROWS = grp_start(-1) + 1;
  localparam int SP_ROW   = NUM_ROWS - 1;

  logic [NUM_COL-1:0]  fuse [NUM_ROWS];
  logic                secure;
  logic [NUM_SIG-1:0]  sig;
  logic [NUM_COL-1:0]  col;
  logic [NUM_ROWS-1:0] term;
  logic [NUM_OUT-1:0]  sop_raw, oe_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_ROWS; r++) fuse[r] <= '0;
      secure <= 1'b0;
    end else if (prog_en) begin
      if (cfg_we && int'(cfg_row) < NUM_ROWS) fuse[cfg_row] <= cfg_data;
      if (cfg_lock) secure <= 1'b1;
    end
  end

  always_comb begin
    if (secure)                     rd_data = '1;
    else if (int'(rd_row) < NUM_ROWS) rd_data = fuse[rd_row];
    else                            rd_data = '0;
  end

  assign sig = {fb, din};

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_col
    assign col[2*s]   = sig[s];
    assign col[2*s+1] = ~sig[s];
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_term
    assign term[r] = &(fuse[r] | col);
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_grp
    localparam int S = grp_start(k);
    localparam int N = term_cnt(k);
    assign oe_raw[k]  = term[S];
    assign sop_raw[k] = |term[S+N:S+1];
  end

  assign sop = prog_en ? '0 : sop_raw;
  assign oe  = prog_en ? '0 : oe_raw;
  assign ar  = ~prog_en & term[0];
  assign sp  = ~prog_en & term[SP_ROW];

endmodule

module sop_plane_chk #(
  parameter int NUM_OUT  = 10,
  parameter int NUM_COL  = 44,
  parameter int NUM_ROWS = 132
) (
  input logic               clk,
  input logic               rst_n,
  input logic               prog_en,
  input logic               cfg_we,
  input logic [7:0]         cfg_row,
  input logic [NUM_COL-1:0] cfg_data,
  input logic               cfg_lock,
  input logic [7:0]         rd_row,
  input logic [NUM_COL-1:0] rd_data,
  input logic [NUM_OUT-1:0] sop,
  input logic [NUM_OUT-1:0] oe,
  input logic               ar,
  input logic               sp,
  input logic               secure
);

  assert_prog_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |-> (sop == '0 && oe == '0 && !ar && !sp));

  assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    secure |=> secure);

  assert_lock_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && cfg_lock) |=> (rd_data == '1));

  assert_idle_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |=> (!$stable(rd_row) || $stable(rd_data)));

  assert_write_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && cfg_we && !cfg_lock && !secure && rd_row == cfg_row &&
     int'(cfg_row) < NUM_ROWS)
    |=> (!$stable(rd_row) || rd_data == $past(cfg_data)));

endmodule

bind sop_plane sop_plane_chk #(
  .NUM_OUT(NUM_OUT), .NUM_COL(NUM_COL), .NUM_ROWS(NUM_ROWS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .cfg_we(cfg_we),
  .cfg_row(cfg_row), .cfg_data(cfg_data), .cfg_lock(cfg_lock),
  .rd_row(rd_row), .rd_data(rd_data), .sop(sop), .oe(oe), .ar(ar),
  .sp(sp), .secure(secure)
);

// File: tb/tb_sop_plane.sv
module tb_sop_plane;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_row = '0;
  logic [43:0] cfg_data = '0;
  logic        cfg_lock = 1'b0;
  logic [7:0]  rd_row = '0;
  logic [43:0] rd_data;
  logic [11:0] din = '0;
  logic [9:0]  fb = '0;
  logic [9:0]  sop, oe;
  logic        ar, sp;

  int checks = 0;
  int errors = 0;

  sop_plane dut (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .cfg_we(cfg_we),
    .cfg_row(cfg_row), .cfg_data(cfg_data), .cfg_lock(cfg_lock),
    .rd_row(rd_row), .rd_data(rd_data), .din(din), .fb(fb),
    .sop(sop), .oe(oe), .ar(ar), .sp(sp)
  );

  always #10 clk = ~clk;

  localparam logic [21:0] STIM [8] = '{
    {10'h000, 12'h000}, {10'h001, 12'h018}, {10'h200, 12'h040},
    {10'h000, 12'h805}, {10'h3FF, 12'hFFF}, {10'h201, 12'h0C2},
    {10'h000, 12'h020}, {10'h200, 12'h8A4}
  };

  function automatic logic [43:0] link(input int a, input int b = -1);
    logic [43:0] w;
    w = '1;
    w[a] = 1'b0;
    if (b >= 0) w[b] = 1'b0;
    return w;
  endfunction

  function automatic logic [21:0] model(input logic [11:0] d, input logic [9:0] f);
    logic [9:0] s, e;
    s = '0; e = '0;
    s[9] = (d[3] & d[4]) | f[0];
    s[4] = d[6] & f[9];
    s[0] = ~d[11];
    e[9] = 1'b1;
    e[4] = ~d[7];
    return {d[0], ~d[1] & d[2], e, s};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int row, input logic [43:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = 8'(row); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic apply(input logic [11:0] d, input logic [9:0] f);
    @(negedge clk);
    din = d; fb = f;
    #2;
  endtask

  task automatic read(input int row);
    @(negedge clk);
    rd_row = 8'(row);
    #2;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    din = '1; fb = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R4 reset outputs", {ar, sp, oe, sop}, 22'h0);
    read(5);
    check("R4 reset readback", rd_data, 0);

    // R8: results forced low while programming, even with all-open rows
    @(negedge clk); prog_en = 1'b1;
    wr(1, '1);
    #2;
    check("R8 low in program mode", {ar, sp, oe, sop}, 22'h0);

    wr(0, link(0));
    wr(131, link(3, 4));
    wr(2, link(6, 8));
    wr(3, link(24));
    wr(130, link(23));
    wr(123, link(10, 11));
    wr(82, link(12, 42));
    wr(66, link(15));
    wr(140, 44'h0);
    read(2);
    check("R9 readback row 2", rd_data, link(6, 8));
    read(123);
    check("R9 readback row 123", rd_data, link(10, 11));
    read(140);
    check("R9 out-of-range read R7", rd_data, 0);
    @(negedge clk); prog_en = 1'b0;

    // R1 R5 R6 R2 R3: table walk
    for (int i = 0; i < 8; i++) begin
      apply(STIM[i][11:0], STIM[i][21:12]);
      check($sformatf("R6 R5 R1 vec %0d", i), {ar, sp, oe, sop},
            model(STIM[i][11:0], STIM[i][21:12]));
    end
    apply(12'h000, 10'h000);
    check("R2 open enable row oe9", 64'(oe[9]), 1);
    apply(12'h820, 10'h000);
    check("R3 contradiction keeps sop0 low", 64'(sop[0]), 0);

    // R7: write while not programming is ignored
    apply(12'h001, 10'h000);
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = 8'd0; cfg_data = '0;
    @(negedge clk);
    cfg_we = 1'b0;
    #2;
    check("R7 idle write ignored ar", 64'(ar), 1);
    read(0);
    check("R7 idle write ignored row0", rd_data, link(0));

    // R10 with simultaneous row write and lock
    @(negedge clk);
    prog_en = 1'b1; cfg_we = 1'b1; cfg_lock = 1'b1;
    cfg_row = 8'd3; cfg_data = link(16);
    @(negedge clk);
    cfg_we = 1'b0; cfg_lock = 1'b0;
    read(3);
    check("R10 locked read row 3", rd_data, 44'hFFF_FFFF_FFFF);
    read(0);
    check("R10 locked read row 0", rd_data, 44'hFFF_FFFF_FFFF);
    @(negedge clk); prog_en = 1'b0;
    apply(12'h100, 10'h000);
    check("R10 new word active sop9", 64'(sop[9]), 1);
    apply(12'h000, 10'h001);
    check("R10 old word gone sop9", 64'(sop[9]), 0);
    apply(12'h001, 10'h000);
    check("R10 array still evaluates ar", 64'(ar), 1);
    read(200);
    check("R10 locked read out of range", rd_data, 44'hFFF_FFFF_FFFF);

    // R4: reset clears lock and rows
    @(negedge clk); rst_n = 1'b0;
    #2;
    check("R4 reset forces outputs low", {ar, sp, oe, sop}, 22'h0);
    @(negedge clk); rst_n = 1'b1;
    read(3);
    check("R4 lock cleared by reset", rd_data, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule